// File: doc/BRIEF.md
# Machine-Cycle Reset Sampler and Sequencer

This block derives the internal reset of a microcontroller core that spends twelve oscillator clocks on each machine cycle. A free-running tick counter splits every machine cycle into six states of two phases each. The asynchronous reset pin is first brought onto the oscillator clock. It is then looked at only once per machine cycle, in the second phase of state 5. The internal reset is raised only after two such samples in a row see the pin high. This keeps a short spike on the pin from resetting the core.

Around the internal reset the block also produces three things. The first is a port-reset signal, delayed so that the port pins keep their activity for a fixed number of clocks after the first high sample. The second is an enable for the address-latch and program-fetch strobes, which drops during reset and comes back on a machine-cycle boundary. The third is a one-cycle load pulse, with a per-register write mask and a value bus, that the special-register file uses to take its reset values. Each register slot is given a kind: cleared, set to all ones, given the stack-pointer start value, or left untouched. Internal data RAM has no connection to this block, so reset never alters it.

Top module: `mc_reset_seq`

## Requirements
- R1: After rst_ni releases, the outputs show state_o=1 and phase_o=0. Each clock then advances phase_o from 0 to 1, and after phase 1 moves state_o to the next value. State 6 phase 1 is followed by state 1 phase 0, so one machine cycle lasts 12 clocks. The tick index (state_o-1)*2+phase_o runs 0..11.
- R2: rst_pin_i passes through two synchronizer flops. It is sampled only on the clock edge that leaves tick index 9 (state 5, phase 1). Pin activity that does not reach a sample point has no effect on any output.
- R3: int_rst_o rises on the second consecutive high sample. It changes only on a sample edge, so after a change the outputs show state_o=6 and phase_o=0.
- R4: A single high sample followed by a low sample leaves int_rst_o, port_rst_o and sfr_load_o low.
- R5: int_rst_o and port_rst_o fall on the first sample that sees the pin low.
- R6: port_rst_o rises exactly PORT_DLY (default 19) clocks after the edge of the first high sample, provided the reset was confirmed. It is high only while int_rst_o is high.
- R7: strobe_en_o falls one clock after int_rst_o rises. After int_rst_o falls, strobe_en_o rises when the counter wraps to state 1 phase 0.
- R8: sfr_load_o is a one-clock pulse on the edge where int_rst_o rises. Register i has a 2-bit kind in SFR_KIND[2i+1:2i], with default 16'h1C49. Kind 0 gives value 00h, kind 1 gives FFh, kind 2 gives SP_INIT (07h), and kind 3 means keep. sfr_we_o[i] equals sfr_load_o for kinds 0 to 2 and is 0 for kind 3. The value of register i appears on sfr_val_o[8i+7:8i], and a keep slot shows 00h.
- R9: While rst_ni is low and right after it releases, int_rst_o=0, port_rst_o=0, sfr_load_o=0 and strobe_en_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset of this block |
| rst_pin_i | input | 1 | Asynchronous reset pin, active high |
| state_o | output | 3 | Current state 1..6 |
| phase_o | output | 1 | Current phase (0 = first, 1 = second) |
| int_rst_o | output | 1 | Internal reset |
| port_rst_o | output | 1 | Port-latch reset after the hold delay |
| strobe_en_o | output | 1 | Enable for the address-latch and fetch strobes |
| sfr_load_o | output | 1 | One-clock reset-value load pulse |
| sfr_we_o | output | NUM_SFR | Per-register write enable for the load |
| sfr_val_o | output | 8*NUM_SFR | Reset value of each register |

## Verification
The assertions check the following on every cycle:
- the state/phase stepping and wrap;
- that the internal reset changes only just after a sample point;
- that the port reset never appears without the internal reset;
- that the strobe enable drops after reset and returns only on a machine-cycle boundary;
- that the load pulse lasts one clock and matches a reset rise.

Only the directed scenarios can show the following:
- the exact 19-clock port delay measured from the first high sample;
- that an isolated high sample or a glitch between sample points is ignored;
- the per-kind reset values;
- the clock on which the strobes come back after release.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  typedef enum logic [1:0] {
    KIND_ZERO  = 2'd0,
    KIND_ONES  = 2'd1,
    KIND_STACK = 2'd2,
    KIND_KEEP  = 2'd3
  } sfr_kind_e;
endpackage

// File: rtl/mcr_tick.sv
module mcr_tick #(
  parameter int unsigned TICKS       = 12,
  parameter int unsigned SAMPLE_TICK = 9,
  localparam int unsigned CW         = $clog2(TICKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] tick_o,
  output logic          sample_o,
  output logic          wrap_o
);
  logic [CW-1:0] tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tick_q <= '0;
    else if (wrap_o) tick_q <= '0;
    else             tick_q <= tick_q + 1'b1;
  end

  assign tick_o   = tick_q;
  assign wrap_o   = (tick_q == CW'(TICKS - 1));
  assign sample_o = (tick_q == CW'(SAMPLE_TICK));
endmodule

// File: rtl/mcr_sampler.sv
module mcr_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic sample_i,
  output logic int_rst_o,
  output logic first_hi_o,
  output logic set_o,
  output logic low_o
);
  logic [1:0] sync_q;
  logic       prev_hi_q, int_rst_q;
  logic       hi_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], pin_i};
  end

  assign hi_evt     = sample_i & sync_q[1];
  assign low_o      = sample_i & ~sync_q[1];
  assign first_hi_o = hi_evt & ~prev_hi_q & ~int_rst_q;
  assign set_o      = hi_evt & prev_hi_q & ~int_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_hi_q <= 1'b0;
      int_rst_q <= 1'b0;
    end else if (sample_i) begin
      prev_hi_q <= sync_q[1];
      if (set_o)      int_rst_q <= 1'b1;
      else if (low_o) int_rst_q <= 1'b0;
    end
  end

  assign int_rst_o = int_rst_q;
endmodule

// File: rtl/mcr_port_delay.sv
module mcr_port_delay #(
  parameter int unsigned DLY = 19,
  localparam int unsigned CW = $clog2(DLY)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clr_i,
  output logic port_rst_o
);
  logic          run_q, port_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      port_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      run_q  <= 1'b0;
      port_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == CW'(DLY - 1)) begin
        port_q <= 1'b1;
        run_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign port_rst_o = port_q;
endmodule

// File: rtl/mcr_sfr_init.sv
module mcr_sfr_init
  import mcr_pkg::*;
#(
  parameter int unsigned        NUM_SFR  = 8,
  parameter logic [2*NUM_SFR-1:0] SFR_KIND = 16'h1C49,
  parameter logic [7:0]         SP_INIT  = 8'h07
) (
  input  logic                 load_i,
  output logic [NUM_SFR-1:0]   we_o,
  output logic [8*NUM_SFR-1:0] val_o
);
  for (genvar i = 0; i < NUM_SFR; i++) begin : g_sfr
    localparam sfr_kind_e KIND = sfr_kind_e'(SFR_KIND[2*i +: 2]);
    if (KIND == KIND_ONES) begin : g_ones
      assign val_o[8*i +: 8] = 8'hFF;
      assign we_o[i]         = load_i;
    end else if (KIND == KIND_STACK) begin : g_stack
      assign val_o[8*i +: 8] = SP_INIT;
      assign we_o[i]         = load_i;
    end else if (KIND == KIND_KEEP) begin : g_keep
      assign val_o[8*i +: 8] = 8'h00;
      assign we_o[i]         = 1'b0;
    end else begin : g_zero
      assign val_o[8*i +: 8] = 8'h00;
      assign we_o[i]         = load_i;
    end
  end
endmodule

// File: rtl/mc_reset_seq.sv
module mc_reset_seq #(
  parameter int unsigned          NUM_SFR  = 8,
  parameter logic [2*NUM_SFR-1:0] SFR_KIND = 16'h1C49,
  parameter logic [7:0]           SP_INIT  = 8'h07,
  parameter int unsigned          PORT_DLY = 19,
  localparam int unsigned         TICKS    = 12,
  localparam int unsigned         SAMPLE_TICK = 9,
  localparam int unsigned         TW       = $clog2(TICKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rst_pin_i,
  output logic [2:0]           state_o,
  output logic                 phase_o,
  output logic                 int_rst_o,
  output logic                 port_rst_o,
  output logic                 strobe_en_o,
  output logic                 sfr_load_o,
  output logic [NUM_SFR-1:0]   sfr_we_o,
  output logic [8*NUM_SFR-1:0] sfr_val_o
);
  logic [TW-1:0] tick;
  logic          sample, wrap;
  logic          first_hi, set_evt, low_evt;
  logic          strobe_q, load_q;

  mcr_tick #(.TICKS(TICKS), .SAMPLE_TICK(SAMPLE_TICK)) i_tick (
    .clk_i, .rst_ni, .tick_o(tick), .sample_o(sample), .wrap_o(wrap)
  );

  mcr_sampler i_sampler (
    .clk_i, .rst_ni, .pin_i(rst_pin_i), .sample_i(sample),
    .int_rst_o, .first_hi_o(first_hi), .set_o(set_evt), .low_o(low_evt)
  );

  mcr_port_delay #(.DLY(PORT_DLY)) i_port (
    .clk_i, .rst_ni, .start_i(first_hi), .clr_i(low_evt), .port_rst_o
  );

  // strobes return on the first machine-cycle boundary after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b1;
      load_q   <= 1'b0;
    end else begin
      load_q <= set_evt;
      if (int_rst_o)  strobe_q <= 1'b0;
      else if (wrap)  strobe_q <= 1'b1;
    end
  end

  mcr_sfr_init #(.NUM_SFR(NUM_SFR), .SFR_KIND(SFR_KIND), .SP_INIT(SP_INIT)) i_sfr (
    .load_i(load_q), .we_o(sfr_we_o), .val_o(sfr_val_o)
  );

  assign state_o     = 3'(tick >> 1) + 3'd1;
  assign phase_o     = tick[0];
  assign strobe_en_o = strobe_q;
  assign sfr_load_o  = load_q;
endmodule

// File: rtl/mcr_checker.sv
module mcr_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] state_o,
  input logic       phase_o,
  input logic       int_rst_o,
  input logic       port_rst_o,
  input logic       strobe_en_o,
  input logic       sfr_load_o
);
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o |=> phase_o && $stable(state_o)); // R1
  AST_STATE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd6 && phase_o) |=> (state_o == 3'd1 && !phase_o)); // R1
  AST_STATE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o >= 3'd1 && state_o <= 3'd6); // R1
  AST_RST_AT_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(int_rst_o) || $fell(int_rst_o)) |-> (state_o == 3'd6 && !phase_o)); // R3
  AST_PORT_NEEDS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_rst_o |-> int_rst_o); // R6
  AST_STROBE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o |=> !strobe_en_o); // R7
  AST_STROBE_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_en_o) |-> (state_o == 3'd1 && !phase_o && !int_rst_o)); // R7
  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_load_o |=> !sfr_load_o); // R8
  AST_LOAD_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_load_o |-> $rose(int_rst_o)); // R8
endmodule

bind mc_reset_seq mcr_checker i_mcr_checker (
  .clk_i, .rst_ni, .state_o, .phase_o, .int_rst_o,
  .port_rst_o, .strobe_en_o, .sfr_load_o
);

// File: tb/test_mc_reset_seq.sv
module test_mc_reset_seq;
  localparam int unsigned NUM_SFR = 8;
  localparam logic [15:0] KINDS = 16'h1C49;

  logic clk = 1'b0, rst_n = 1'b0, pin = 1'b0;
  logic [2:0] state;
  logic phase, int_rst, port_rst, strobe_en, sfr_load;
  logic [NUM_SFR-1:0] sfr_we;
  logic [8*NUM_SFR-1:0] sfr_val;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  mc_reset_seq i_mc_reset_seq (
    .clk_i(clk), .rst_ni(rst_n), .rst_pin_i(pin), .state_o(state), .phase_o(phase),
    .int_rst_o(int_rst), .port_rst_o(port_rst), .strobe_en_o(strobe_en),
    .sfr_load_o(sfr_load), .sfr_we_o(sfr_we), .sfr_val_o(sfr_val)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int idx();
    return (int'(state) - 1) * 2 + int'(phase);
  endfunction

  task automatic wait_idx(input int k);
    @(negedge clk);
    while (idx() != k) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(int_rst == 0 && port_rst == 0 && sfr_load == 0, "R9 outputs low in reset", int_rst, 0);
    chk(strobe_en == 1, "R9 strobe enabled in reset", strobe_en, 1);
    @(negedge clk) rst_n = 1'b1;
    chk(state == 1 && phase == 0, "R1 start state", idx(), 0);
    chk(int_rst == 0 && strobe_en == 1, "R9 after release", int_rst, 0);
  endtask

  task automatic t_counter;
    wait_idx(0);
    for (int n = 1; n <= 24; n++) begin
      @(negedge clk);
      chk(idx() == n % 12, "R1 tick sequence", idx(), n % 12);
    end
  endtask

  task automatic t_full_reset;
    wait_idx(7); pin = 1'b1;
    wait_idx(10);
    chk(int_rst == 0, "R3 first sample only", int_rst, 0);
    repeat (11) @(negedge clk);
    chk(int_rst == 0, "R3 not before second sample", int_rst, 0);
    @(negedge clk);
    chk(int_rst == 1, "R3 rise on second sample", int_rst, 1);
    chk(state == 6 && phase == 0, "R3 rise at sample edge", idx(), 10);
    chk(sfr_load == 1, "R8 load pulse", sfr_load, 1);
    chk(strobe_en == 1, "R7 strobe still on", strobe_en, 1);
    for (int i = 0; i < NUM_SFR; i++) begin
      int k = int'(KINDS[2*i +: 2]);
      int ev = (k == 1) ? 255 : (k == 2) ? 7 : 0;
      chk(int'(sfr_val[8*i +: 8]) == ev, "R8 reset value", int'(sfr_val[8*i +: 8]), ev);
      chk(sfr_we[i] == (k != 3), "R8 write mask", sfr_we[i], int'(k != 3));
    end
    @(negedge clk);
    chk(sfr_load == 0 && sfr_we == '0, "R8 single pulse", sfr_load, 0);
    chk(strobe_en == 0, "R7 strobe off", strobe_en, 0);
    repeat (5) @(negedge clk);
    chk(port_rst == 0, "R6 port held at 18", port_rst, 0);
    @(negedge clk);
    chk(port_rst == 1, "R6 port reset at 19", port_rst, 1);
    repeat (30) @(negedge clk);
    chk(int_rst == 1 && port_rst == 1 && strobe_en == 0, "R3 reset held", int_rst, 1);
    wait_idx(7); pin = 1'b0;
    wait_idx(9);
    chk(int_rst == 1, "R5 held until sample", int_rst, 1);
    @(negedge clk);
    chk(int_rst == 0 && port_rst == 0, "R5 release on low sample", int_rst, 0);
    chk(strobe_en == 0, "R7 strobe off after release", strobe_en, 0);
    @(negedge clk);
    chk(strobe_en == 0, "R7 strobe waits boundary", strobe_en, 0);
    @(negedge clk);
    chk(strobe_en == 1 && idx() == 0, "R7 strobe on at boundary", strobe_en, 1);
  endtask

  task automatic t_single_sample;
    int seen = 0;
    wait_idx(7); pin = 1'b1;
    wait_idx(7); pin = 1'b0;
    repeat (36) begin
      @(negedge clk);
      if (int_rst || port_rst || sfr_load || !strobe_en) seen++;
    end
    chk(seen == 0, "R4 single high sample ignored", seen, 0);
  endtask

  task automatic t_glitch;
    int seen = 0;
    wait_idx(0); pin = 1'b1;
    repeat (4) @(negedge clk);
    pin = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (int_rst || port_rst || sfr_load || !strobe_en) seen++;
    end
    chk(seen == 0, "R2 glitch between samples ignored", seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_counter();
    t_glitch();
    t_single_sample();
    t_full_reset();
    t_glitch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule